// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block sits between a one-bit comparator result and the interrupt and timer logic of a chip. The comparator result arrives as an asynchronous digital level. The block synchronizes it and watches it for the kind of transition that software has chosen: rising only, falling only, or any change. A matching transition sets a sticky event flag. The flag drives an interrupt request when both the local enable and the global interrupt enable are on.

Software controls the block through a single 8-bit register. Besides the flag and the enable, the register holds a power-off bit that silences the comparator, a route bit that forwards the comparator level to a timer's input-capture trigger, and a read-only copy of the synchronized comparator level. The flag can be cleared in two ways: software writes a one to it, or the interrupt vector logic acknowledges the request.

Top module: `cmp_evt_top`

## Requirements
- R1: After reset, every register bit reads zero except bit 5, which shows the synchronized comparator level. With the input low, the register reads 0x00.
- R2: Bit 6 always reads zero, and a write of one to bit 6 has no effect.
- R3: Bit 5 reads one when the comparator input is high. It follows an input change after two clock edges and is read-only.
- R4: Bits 1:0 select the edge mode: 00 sets the flag on any change, 01 sets it on no event, 10 on a falling edge and 11 on a rising edge. The flag (bit 4) sets on the third clock edge after the input changes.
- R5: The output irqOut is high exactly while the flag, the interrupt enable (bit 3) and globalIntEn are all one.
- R6: A register write with bit 4 at one clears the flag. A write with bit 4 at zero leaves the flag unchanged.
- R7: A one-cycle pulse on vecAck clears the flag.
- R8: When an event and a clear (write-one or acknowledge) fall in the same cycle, the flag ends set.
- R9: captureTrig equals the bit 5 level while bit 2 is one, and is zero while bit 2 is zero.
- R10: While bit 7 is one, bit 5 reads zero, captureTrig stays zero and no input change sets the flag.
- R11: Bits 7, 3, 2 and 1:0 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| cmpIn | input | 1 | Asynchronous comparator result |
| globalIntEn | input | 1 | Global interrupt enable |
| vecAck | input | 1 | Interrupt vector acknowledge (clears the flag) |
| irqOut | output | 1 | Interrupt request |
| captureTrig | output | 1 | Input-capture trigger for the timer |

## Verification
Each of the four edge modes is driven with a low-to-high and a high-to-low transition. This separates rising, falling, toggle and the silent code, and it would expose swapped mode encodings. Directed runs then time the flag against the third clock edge and the level bit against the second. They place an acknowledge in the same cycle as an event to show which action takes priority. They also step the three inputs of the request gate one at a time and toggle the input while the power-off bit is set.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int REG_W = 8;
  localparam int BIT_OFF  = 7;
  localparam int BIT_RSV  = 6;
  localparam int BIT_LVL  = 5;
  localparam int BIT_FLAG = 4;
  localparam int BIT_IE   = 3;
  localparam int BIT_CAP  = 2;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_NONE   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } edgeMode_t;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic loadCfg;
  } cmpStrobe_t;
endpackage

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       wrFlagBit,
  input  logic       vecAck,
  input  logic       offQ,
  input  edgeMode_t  modeQ,
  input  logic       riseSeen,
  input  logic       fallSeen,
  output cmpStrobe_t strb
);
  logic modeHit;

  always_comb begin
    unique case (modeQ)
      MODE_TOGGLE: modeHit = riseSeen | fallSeen;
      MODE_FALL:   modeHit = fallSeen;
      MODE_RISE:   modeHit = riseSeen;
      default:     modeHit = 1'b0;
    endcase
  end

  always_comb begin
    strb.setFlag = modeHit & ~offQ;
    strb.clrFlag = vecAck | (regWrEn & wrFlagBit);
    strb.loadCfg = regWrEn;
  end

  // R4: the reserved mode code never raises the flag
  a_r4_none_mode_silent: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_NONE) |-> !strb.setFlag);

  // R4: the rising mode ignores falling transitions
  a_r4_rise_only: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_RISE && fallSeen) |-> !strb.setFlag);

  // R10: powered-off comparator produces no events
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    offQ |-> !strb.setFlag);
endmodule

// File: rtl/cmp_evt_dp.sv
module cmp_evt_dp
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  input  logic             wrOff,
  input  logic [3:0]       wrLow,
  input  cmpStrobe_t       strb,
  output logic             offQ,
  output edgeMode_t        modeQ,
  output logic             ieQ,
  output logic             capQ,
  output logic             flagQ,
  output logic             lvl,
  output logic             riseSeen,
  output logic             fallSeen,
  output logic [REG_W-1:0] regRd
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] syncQ;
  logic         prevQ;

  generate
    if (SYNC_STAGES == 1) begin : g_oneStage
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= cmpIn;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[MSB-1:0], cmpIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[MSB];

  assign riseSeen = syncQ[MSB] & ~prevQ;
  assign fallSeen = ~syncQ[MSB] & prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ  <= 1'b0;
      ieQ   <= 1'b0;
      capQ  <= 1'b0;
      modeQ <= MODE_TOGGLE;
    end else if (strb.loadCfg) begin
      offQ  <= wrOff;
      ieQ   <= wrLow[3];
      capQ  <= wrLow[2];
      modeQ <= edgeMode_t'(wrLow[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             flagQ <= 1'b0;
    else if (strb.setFlag) flagQ <= 1'b1;
    else if (strb.clrFlag) flagQ <= 1'b0;

  assign lvl = syncQ[MSB] & ~offQ;

  always_comb begin
    regRd           = '0;
    regRd[BIT_OFF]  = offQ;
    regRd[BIT_RSV]  = 1'b0;
    regRd[BIT_LVL]  = lvl;
    regRd[BIT_FLAG] = flagQ;
    regRd[BIT_IE]   = ieQ;
    regRd[BIT_CAP]  = capQ;
    regRd[1:0]      = modeQ;
  end

  // R8: an event always leaves the flag set, whatever clears arrive
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFlag |=> flagQ);

  // R7 / R6: a clear without an event empties the flag
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag && !strb.setFlag) |=> !flagQ);

  // R6: without set or clear the flag holds
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrFlag && !strb.setFlag) |=> (flagQ == $past(flagQ)));
endmodule

// File: rtl/cmp_evt_top.sv
module cmp_evt_top
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             cmpIn,
  input  logic             globalIntEn,
  input  logic             vecAck,
  output logic             irqOut,
  output logic             captureTrig
);
  cmpStrobe_t strb;
  edgeMode_t  modeQ;
  logic offQ, ieQ, capQ, flagQ, lvl, riseSeen, fallSeen;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[BIT_RSV:BIT_LVL];

  cmp_evt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .wrFlagBit (regWrData[BIT_FLAG]),
    .vecAck    (vecAck),
    .offQ      (offQ),
    .modeQ     (modeQ),
    .riseSeen  (riseSeen),
    .fallSeen  (fallSeen),
    .strb      (strb)
  );

  cmp_evt_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmpIn    (cmpIn),
    .wrOff    (regWrData[BIT_OFF]),
    .wrLow    (regWrData[3:0]),
    .strb     (strb),
    .offQ     (offQ),
    .modeQ    (modeQ),
    .ieQ      (ieQ),
    .capQ     (capQ),
    .flagQ    (flagQ),
    .lvl      (lvl),
    .riseSeen (riseSeen),
    .fallSeen (fallSeen),
    .regRd    (regRdData)
  );

  assign irqOut      = flagQ & ieQ & globalIntEn;
  assign captureTrig = lvl & capQ;

  // R5: a request needs the global enable and the register's flag and enable
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (globalIntEn && regRdData[BIT_FLAG] && regRdData[BIT_IE]));

  // R9: trigger only when routed
  a_r9_cap_routed: assert property (@(posedge clk) disable iff (!rstN)
    captureTrig |-> (regRdData[BIT_CAP] && regRdData[BIT_LVL]));

  // R10: comparator level reads low while powered off
  a_r10_off_level: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[BIT_OFF] |-> !regRdData[BIT_LVL]);
endmodule

// File: tb/sim_cmp_evt_top.sv
`timescale 1ns/1ps
module sim_cmp_evt_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic cmpIn = 1'b0;
  logic globalIntEn = 1'b0;
  logic vecAck = 1'b0;
  logic irqOut, captureTrig;

  int checkCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  cmp_evt_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cmpIn(cmpIn), .globalIntEn(globalIntEn),
    .vecAck(vecAck), .irqOut(irqOut), .captureTrig(captureTrig)
  );

  // {mode[1:0], startLevel, endLevel, expectedFlag}
  localparam logic [4:0] VEC [8] = '{
    {2'b00, 1'b0, 1'b1, 1'b1}, {2'b00, 1'b1, 1'b0, 1'b1},
    {2'b01, 1'b0, 1'b1, 1'b0}, {2'b01, 1'b1, 1'b0, 1'b0},
    {2'b10, 1'b0, 1'b1, 1'b0}, {2'b10, 1'b1, 1'b0, 1'b1},
    {2'b11, 1'b0, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    chk("R1 reset value", regRdData, 8'h00);
    chk("R1 irq after reset", {7'b0, irqOut}, 8'h00);

    // vector table: all modes, both directions
    globalIntEn = 1'b1;
    foreach (VEC[i]) begin
      cmpIn = VEC[i][2];
      wrReg({4'b0001, 2'b10, VEC[i][4:3]});
      tick(4);
      wrReg({4'b0001, 2'b10, VEC[i][4:3]});
      chk("R4 flag cleared before edge", {7'b0, regRdData[4]}, 8'h00);
      cmpIn = VEC[i][1];
      tick(5);
      chk("R4 edge mode result", {7'b0, regRdData[4]}, {7'b0, VEC[i][0]});
      chk("R5 irq follows flag", {7'b0, irqOut}, {7'b0, VEC[i][0]});
    end

    // R4 latency, R3 level timing
    cmpIn = 1'b0;
    wrReg(8'h10);
    tick(4);
    wrReg(8'h10);
    cmpIn = 1'b1;
    tick(1);
    chk("R3 level not yet visible", {7'b0, regRdData[5]}, 8'h00);
    tick(1);
    chk("R3 level after two edges", {7'b0, regRdData[5]}, 8'h01);
    chk("R4 flag not yet set", {7'b0, regRdData[4]}, 8'h00);
    tick(1);
    chk("R4 flag on third edge", {7'b0, regRdData[4]}, 8'h01);

    // R6 write zero keeps, write one clears; R11 readback; R2 reserved
    wrReg(8'h4D);
    chk("R11 R2 readback keeps flag", regRdData, 8'h3D);
    wrReg(8'h5D);
    chk("R6 write-one clears flag", regRdData, 8'h2D);

    // R9 capture routing (bit 2 set from previous write)
    chk("R9 routed trigger", {7'b0, captureTrig}, 8'h01);
    wrReg(8'h08);
    chk("R9 unrouted trigger", {7'b0, captureTrig}, 8'h00);

    // R5 gate: make flag, then step enables
    cmpIn = 1'b0;
    tick(4);
    chk("R4 toggle sets on fall", {7'b0, regRdData[4]}, 8'h01);
    globalIntEn = 1'b0;
    tick(1);
    chk("R5 global off blocks irq", {7'b0, irqOut}, 8'h00);
    globalIntEn = 1'b1;
    tick(1);
    chk("R5 all enabled", {7'b0, irqOut}, 8'h01);
    wrReg(8'h00);
    chk("R5 local enable off blocks irq", {7'b0, irqOut}, 8'h00);

    // R7 acknowledge clears
    vecAck = 1'b1;
    tick(1);
    vecAck = 1'b0;
    chk("R7 ack clears flag", regRdData, 8'h00);

    // R8 event and ack in the same cycle
    cmpIn = 1'b1;
    tick(2);
    vecAck = 1'b1;
    tick(1);
    vecAck = 1'b0;
    chk("R8 set beats ack", {7'b0, regRdData[4]}, 8'h01);
    wrReg(8'h10);
    cmpIn = 1'b0;
    tick(2);
    regWrEn = 1'b1;
    regWrData = 8'h10;
    tick(1);
    regWrEn = 1'b0;
    regWrData = '0;
    chk("R8 set beats write-one", {7'b0, regRdData[4]}, 8'h01);

    // R10 power off
    wrReg(8'h10);
    wrReg(8'h8C);
    cmpIn = 1'b1;
    tick(4);
    chk("R10 level forced low", {7'b0, regRdData[5]}, 8'h00);
    chk("R10 trigger held low", {7'b0, captureTrig}, 8'h00);
    cmpIn = 1'b0;
    tick(4);
    cmpIn = 1'b1;
    tick(4);
    chk("R10 no events while off", regRdData, 8'h8C);
    wrReg(8'h0C);
    tick(1);
    chk("R10 level returns when on", regRdData, 8'h2C);

    finishRun();
  end
endmodule